// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Register Pointer

This block is a byte-wide I2C target for a bank of eight registers. It works from a system clock that oversamples SCL and SDA, finds START, repeated START and STOP, shifts in the device-address, word-address and data bytes, and pulls SDA low for acknowledges and read data. It never drives SDA high. A 3-bit pointer selects the register. A word-address byte loads the pointer. The pointer steps forward after each written byte and after each read byte that the master acknowledges.

The register file sits outside the block. Writes reach it as a one-cycle strobe with address and data. Reads use a combinational read port addressed by the pointer. A freeze output tells a time-keeping register file to hold its counters while the master is reading one of the time registers, so that a multi-byte read sees a coherent snapshot. Reads can follow a word-address write and a repeated START. A read can also start straight at the stored pointer.

Top module: `i2c_regptr_target`

## Requirements
- R1: The block answers only to device address 7'b1101000 (byte 0xD0 to write, 0xD1 to read; R/W is bit 0). For any other address it sends no ACK, writes nothing, leaves the pointer unchanged and ignores the bus until the next START or STOP.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START at any point, a repeated START included, restarts the device-address phase. After STOP the block is idle with SDA released.
- R3: In a write transfer the target ACKs the device-address byte (R/W=0), the word-address byte and every data byte, by holding SDA low during the ninth SCL pulse.
- R4: The word-address byte loads its low 3 bits into the pointer. Each written data byte gives exactly one single-cycle write strobe, with the current pointer as address and the byte as data. The pointer then increments.
- R5: After a read address byte (0xD1) is acknowledged, the target sends the register at the pointer, MSB first. It changes SDA only while SCL is low.
- R6: During a read the pointer increments only when the master ACKs a byte. After a master NACK the target releases SDA, and the pointer keeps the address of the NACKed byte.
- R7: A read with no word-address phase starts at the pointer value stored by earlier transfers.
- R8: The pointer is 3 bits wide and wraps from 7 to 0, for both writes and reads.
- R9: The freeze output is high while the target is sending read data and the pointer is in 0 to 6. It is low at pointer 7, during writes and when the bus is idle.
- R10: After reset SDA is released, no write strobe is issued, freeze is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 3 | Register address for the write strobe |
| wr_data_o | output | 8 | Register data for the write strobe |
| rd_addr_o | output | 3 | Current pointer, read address for the register file |
| rd_data_i | input | 8 | Register file read data at rd_addr_o |
| freeze_o | output | 1 | Hold time registers during a read |

## Verification
Two things happen on the same SCL rise: the master's ACK at the end of a read byte moves the pointer, and freeze is recomputed from the new pointer. A mistake in either shows up as a wrong byte or a wrong freeze level. The bench provokes this by streaming a read from register 5 across 6, 7 and the wrap to 0. At every sampled data bit it compares freeze with a pointer model kept in the bench: high, high, low, high. Each returned byte is compared with the bench's own register image, so a late or missing pointer step is caught in the same transfer.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WORD,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } rp_state_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = 4;
  localparam logic [CNT_W-1:0] CNT_ACK  = 4'd8;
  localparam logic [CNT_W-1:0] CNT_DONE = 4'd9;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_s, sda_s;
  logic scl_q, sda_q, scl_c, sda_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[STAGES-2:0], scl_i};
      sda_s <= {sda_s[STAGES-2:0], sda_i};
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  assign scl_c      = scl_s[STAGES-1];
  assign sda_c      = sda_s[STAGES-1];
  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_q;
  assign scl_fall_o = ~scl_c & scl_q;
  assign start_o    = scl_c & scl_q & sda_q & ~sda_c;
  assign stop_o     = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + 1'b1; // natural wrap
  end
endmodule

// File: rtl/i2c_rp_fsm.sv
module i2c_rp_fsm
  import i2c_rp_pkg::*;
#(
  parameter int unsigned AW       = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [AW-1:0]     ptr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              ptr_load_o,
  output logic [AW-1:0]     ptr_val_o,
  output logic              ptr_inc_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              reading_o
);
  rp_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              rw_q, acked_q, oe_q;
  logic              active;

  assign active = (state_q != ST_IDLE) && (state_q != ST_SKIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      acked_q   <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (active && scl_rise_i) begin
        if (cnt_q < CNT_ACK) begin
          cnt_q <= cnt_q + 1'b1;
          if (state_q != ST_RDATA) rx_q <= {rx_q[BYTE_W-2:0], sda_i};
        end else if (cnt_q == CNT_DONE && state_q == ST_RDATA) begin
          acked_q <= ~sda_i;
        end
      end else if (active && scl_fall_i) begin
        if (cnt_q == CNT_ACK) begin
          cnt_q <= CNT_DONE;
          unique case (state_q)
            ST_ADDR: begin
              if (rx_q[7:1] == DEV_ADDR) begin
                oe_q <= 1'b1;
                rw_q <= rx_q[0];
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_WORD:  oe_q <= 1'b1;
            ST_WDATA: begin
              oe_q      <= 1'b1;
              wr_en_o   <= 1'b1;
              wr_addr_o <= ptr_i;
              wr_data_o <= rx_q;
            end
            default:  oe_q <= 1'b0; // read: master owns the ack slot
          endcase
        end else if (cnt_q == CNT_DONE) begin
          cnt_q <= '0;
          unique case (state_q)
            ST_ADDR: begin
              if (rw_q) begin
                state_q <= ST_RDATA;
                tx_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else begin
                state_q <= ST_WORD;
                oe_q    <= 1'b0;
              end
            end
            ST_WORD: begin
              state_q <= ST_WDATA;
              oe_q    <= 1'b0;
            end
            ST_RDATA: begin
              if (acked_q) begin
                tx_q <= rd_data_i;
                oe_q <= ~rd_data_i[7];
              end else begin
                state_q <= ST_SKIP;
                oe_q    <= 1'b0;
              end
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (state_q == ST_RDATA && cnt_q != '0) begin
          oe_q <= ~tx_q[6];
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    ptr_load_o = (state_q == ST_WORD) && scl_fall_i && (cnt_q == CNT_ACK);
    ptr_val_o  = rx_q[AW-1:0];
    ptr_inc_o  = ((state_q == ST_WDATA) && scl_fall_i && (cnt_q == CNT_ACK)) ||
                 ((state_q == ST_RDATA) && scl_rise_i && (cnt_q == CNT_DONE) && !sda_i);
  end

  assign sda_oe_o  = oe_q;
  assign reading_o = (state_q == ST_RDATA);
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_rp_pkg::*;
#(
  parameter int unsigned AW        = 3,
  parameter int unsigned TIME_REGS = 7,
  parameter int unsigned SYNC      = 2,
  parameter logic [6:0]  DEV_ADDR  = 7'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              freeze_o
);
  localparam logic [AW-1:0] TIME_LIM = AW'(TIME_REGS);

  logic          sda_w, rise_w, fall_w, start_w, stop_w;
  logic          load_w, inc_w, reading_w;
  logic [AW-1:0] load_val_w, ptr_w;

  i2c_rp_sync #(.STAGES(SYNC)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_w), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_rp_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni,
    .load_i(load_w), .load_val_i(load_val_w), .inc_i(inc_w), .ptr_o(ptr_w)
  );

  i2c_rp_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .sda_i(sda_w), .scl_rise_i(rise_w), .scl_fall_i(fall_w),
    .start_i(start_w), .stop_i(stop_w),
    .ptr_i(ptr_w), .rd_data_i,
    .ptr_load_o(load_w), .ptr_val_o(load_val_w), .ptr_inc_o(inc_w),
    .sda_oe_o, .wr_en_o, .wr_addr_o, .wr_data_o,
    .reading_o(reading_w)
  );

  assign rd_addr_o = ptr_w;
  assign freeze_o  = reading_w && (ptr_w < TIME_LIM);
endmodule

// File: rtl/i2c_rp_chk.sv
module i2c_rp_chk #(
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          freeze_o,
  input logic          stop_w
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R4

  AST_PTR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> rd_addr_o == AW'(wr_addr_o + 1'b1)); // R8

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R5

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_o); // R2

  AST_NO_FREEZE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !freeze_o); // R9
endmodule

bind i2c_regptr_target i2c_rp_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .rd_addr_o(rd_addr_o),
  .freeze_o(freeze_o), .stop_w(stop_w)
);

// File: tb/test_i2c_regptr_target.sv
module test_i2c_regptr_target;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe, wr_en, freeze;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire        sda_bus = m_sda & ~sda_oe;

  logic [7:0]  regs  [8];
  logic [7:0]  mreg  [8];
  logic [10:0] expq  [$];
  int          mptr = 0;
  int          ncmp = 0, nfail = 0;
  bit          in_read = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  i2c_regptr_target i_i2c_regptr_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .freeze_o(freeze)
  );

  assign rd_data = regs[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= 8'h10 + 8'(i);
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model comparison: strobes against expected queue, freeze when no read is open
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_en) begin
        if (expq.size() == 0) chk("R4 unexpected write strobe", {21'd0, wr_addr, wr_data}, 32'h0);
        else chk("R4 write strobe addr/data", {21'd0, wr_addr, wr_data}, {21'd0, expq.pop_front()});
      end
      if (!in_read) chk("R9 freeze outside read", {31'd0, freeze}, 32'd0);
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; w(H); scl = 1'b1; w(H); m_sda = 1'b0; w(H); scl = 1'b0; w(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; w(H); scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; w(H); scl = 1'b1; w(H); scl = 1'b0; w(H);
  endtask

  task automatic recv_bit(output logic b, output logic f);
    m_sda = 1'b1; w(H); scl = 1'b1; w(H/2); b = sda_bus; f = freeze; w(H/2); scl = 1'b0; w(H);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic b, f;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b, f);
    ack = ~b;
  endtask

  task automatic read_byte(input logic ack_it, input logic exp_frz, output logic [7:0] v,
                           output logic frz_ok);
    logic b, f;
    frz_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b, f);
      v[i] = b;
      if (f !== exp_frz) frz_ok = 1'b0;
    end
    send_bit(~ack_it);
  endtask

  task automatic write_regs(input logic [2:0] word, input logic [7:0] d [$]);
    logic ack;
    bus_start;
    write_byte(8'hD0, ack); chk("R3 ack device address", {31'd0, ack}, 32'd1);
    write_byte({5'd0, word}, ack); chk("R3 ack word address", {31'd0, ack}, 32'd1);
    mptr = word;
    foreach (d[i]) begin
      expq.push_back({mptr[2:0], d[i]});
      mreg[mptr] = d[i];
      write_byte(d[i], ack); chk("R3 ack data byte", {31'd0, ack}, 32'd1);
      mptr = (mptr + 1) % 8;
    end
    bus_stop; w(4);
    chk("R4 pointer after write", {29'd0, rd_addr}, mptr);
  endtask

  task automatic read_regs(input bit random, input logic [2:0] word, input int n);
    logic ack, fok;
    logic [7:0] v;
    if (random) begin
      bus_start;
      write_byte(8'hD0, ack); chk("R5 ack device address", {31'd0, ack}, 32'd1);
      write_byte({5'd0, word}, ack); chk("R5 ack word address", {31'd0, ack}, 32'd1);
      mptr = word;
    end
    in_read = 1'b1;
    bus_start;
    write_byte(8'hD1, ack); chk("R7 ack read address", {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, mptr < 7, v, fok);
      chk(random ? "R5 read data" : "R7 current-address read data", v, mreg[mptr]);
      chk("R9 freeze during read byte", {31'd0, fok}, 32'd1);
      if (i < n - 1) mptr = (mptr + 1) % 8;
    end
    chk("R6 SDA released after NACK", {31'd0, sda_oe}, 32'd0);
    in_read = 1'b0;
    bus_stop; w(4);
    chk("R6 pointer holds NACKed address", {29'd0, rd_addr}, mptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      ncmp++; nfail++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
      $finish;
    end
  end

  initial begin
    logic ack, fok;
    logic [7:0] v;
    for (int i = 0; i < 8; i++) mreg[i] = 8'h10 + 8'(i);
    w(5);
    chk("R10 SDA released in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    w(5);
    chk("R10 pointer after reset", {29'd0, rd_addr}, 32'd0);
    chk("R10 freeze after reset", {31'd0, freeze}, 32'd0);
    chk("R10 no strobe after reset", {31'd0, wr_en}, 32'd0);

    // R3 R4: burst write from 2
    write_regs(3'd2, '{8'hA5, 8'h3C, 8'h81});
    // R5 R6: random read of two bytes from 2
    read_regs(1'b1, 3'd2, 2);
    // R7: current-address read continues from the stored pointer (3)
    read_regs(1'b0, 3'd0, 2);
    // R8: write burst wraps 6 -> 7 -> 0
    write_regs(3'd6, '{8'h5A, 8'hC3, 8'h0F});
    // R9 R8: read stream 5,6,7,0 with freeze 1,1,0,1
    read_regs(1'b1, 3'd5, 4);

    // R1: wrong device address, then bytes that must be ignored
    bus_start;
    write_byte(8'hD2, ack); chk("R1 no ack for foreign address", {31'd0, ack}, 32'd0);
    write_byte(8'h05, ack); chk("R1 ignored byte not acked", {31'd0, ack}, 32'd0);
    write_byte(8'h77, ack); chk("R1 ignored byte not acked", {31'd0, ack}, 32'd0);
    bus_stop; w(4);
    chk("R1 pointer untouched", {29'd0, rd_addr}, mptr);
    read_regs(1'b0, 3'd0, 1);

    // R2: repeated START right after a data byte switches to read at pointer 5
    bus_start;
    write_byte(8'hD0, ack); chk("R2 ack device address", {31'd0, ack}, 32'd1);
    write_byte(8'h04, ack); chk("R2 ack word address", {31'd0, ack}, 32'd1);
    expq.push_back({3'd4, 8'h99}); mreg[4] = 8'h99;
    write_byte(8'h99, ack); chk("R2 ack data byte", {31'd0, ack}, 32'd1);
    mptr = 5;
    in_read = 1'b1;
    bus_start;
    write_byte(8'hD1, ack); chk("R2 ack after repeated START", {31'd0, ack}, 32'd1);
    read_byte(1'b0, 1'b1, v, fok);
    chk("R2 read after repeated START", v, mreg[5]);
    chk("R9 freeze on register 5", {31'd0, fok}, 32'd1);
    in_read = 1'b0;
    bus_stop; w(4);
    chk("R2 idle and released after STOP", {31'd0, sda_oe}, 32'd0);
    chk("R4 all expected strobes seen", expq.size(), 32'd0);

    w(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  end
endmodule